// File: doc/BRIEF.md
# Page-Gated Scratch RAM Controller

This block is a small on-chip scratch RAM split into four pages of equal size. An 8-bit control register holds one enable bit per page. A CPU-side bus carries RAM reads and writes, and a separate register port reads and writes the control register. Writes to a switched-off page are dropped. Reads from a switched-off page return a poison pattern chosen by a parameter.

Every RAM write first lands in a single-entry posted-write buffer. The buffer commits to the array in the following clock cycle, whether or not that cycle carries a new access. The enable bit is checked again at commit. A page switched off in the same cycle as a write to it therefore loses that write, which is the software hazard the block models. Any RAM access made in the cycle right after a control-register write is still performed, but it raises a hazard flag.

The RAM bus accepts an access on every cycle in which `ram_valid` is high. Read data is returned one cycle later with `ram_rvalid`.

Top module: `pgram_top`

## Requirements
- R1: After reset, a byte read of the control register returns 8'hFF, all four pages are enabled and `reg_err` is 0.
- R2: Control-register bits 7 to 4 always read as 1, whatever value is written to them.
- R3: A control-register write with `reg_size` = 2'd0 (byte) sets page enables 3..0 from `reg_wdata[3:0]` one clock after the write is accepted. A byte read in that later cycle returns the new value.
- R4: A control-register access with `reg_size` other than 2'd0 does not change the register. During such an access `reg_rdata` is 8'h00 and `reg_err` is 1.
- R5: A RAM write to a page whose enable bit is 0 leaves the array contents unchanged. The page is selected by the two most significant bits of `ram_addr`, and enable bit n gates page n.
- R6: A RAM read from a disabled page returns `POISON` (default 32'hDEADDEAD), with `ram_rvalid` high one cycle after the request.
- R7: A RAM read from an enabled page returns the stored word one cycle after the request. This includes a word written in the cycle just before the read.
- R8: A posted write commits in the cycle after it is accepted. If its page's enable bit is 0 in that commit cycle, the write is lost.
- R9: `ram_hazard` is 1 during a RAM access made in the cycle right after an accepted control-register write, and 0 for RAM accesses at any other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ram_valid | input | 1 | RAM access request |
| ram_we | input | 1 | 1 = write, 0 = read |
| ram_addr | input | AW (PAGE_AW+2) | Word address; top two bits select the page |
| ram_wdata | input | DW | Write data |
| ram_rdata | output | DW | Read data, one cycle after request |
| ram_rvalid | output | 1 | Read data valid |
| ram_hazard | output | 1 | Access issued right after a control-register write |
| reg_valid | input | 1 | Control-register access request |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_size | input | 2 | Access width code: 0 byte, 1 half, 2 word |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, same cycle |
| reg_err | output | 1 | Access width error |

## Verification
The bench targets six corner cases:

- **Posted write meets a disable.** A RAM write and a page disable are issued in the same cycle. An old value must survive, which shows the commit re-checks the enable. A design that checked the enable only at capture would keep the new word.
- **Read right after a write.** A read to the same address in the very next cycle must return the new word. A design without forwarding from the buffer would return the stale array word.
- **Disabled page.** A write to a switched-off page must not land, and a read from it must return the poison pattern. A design that ignored the enable would return real data or corrupt the old word.
- **Reserved bits.** They must read as 1 after zeros are written to them.
- **Non-byte accesses.** These must leave the enables untouched and raise the error flag.
- **Hazard flag.** It must be high in exactly the first cycle after a register write and low one cycle later.

// File: rtl/pgram_pkg.sv
package pgram_pkg;
    localparam int unsigned NPAGE   = 4;
    localparam int unsigned PAGE_W  = 2;
    localparam logic [1:0]  SZ_BYTE = 2'd0;

    typedef enum logic [1:0] {
        SRC_ARRAY  = 2'd0,
        SRC_FWD    = 2'd1,
        SRC_POISON = 2'd2
    } rsrc_e;
endpackage

// File: rtl/pgram_ctrl_reg.sv
module pgram_ctrl_reg
    import pgram_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_valid,
    input  logic             reg_we,
    input  logic [1:0]       reg_size,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    output logic             reg_err,
    output logic [NPAGE-1:0] page_en,
    output logic             wr_last
);
    typedef struct packed {
        logic [NPAGE-1:0] en;
        logic             hz;
    } st_t;

    st_t  st_d, st_q;
    logic byte_ok;
    logic wr_acc;

    always_comb begin
        byte_ok = (reg_size == SZ_BYTE);
        wr_acc  = reg_valid && reg_we && byte_ok;
        st_d    = st_q;
        st_d.hz = wr_acc;
        if (wr_acc) begin
            st_d.en = reg_wdata[NPAGE-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.en <= '1;
            st_q.hz <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign reg_rdata = (reg_valid && !reg_we && byte_ok) ? {{(8-NPAGE){1'b1}}, st_q.en} : 8'h00;
    assign reg_err   = reg_valid && !byte_ok;
    assign page_en   = st_q.en;
    assign wr_last   = st_q.hz;

    // R3: an accepted byte write lands in the enables one clock later
    assert_en_update_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_valid && reg_we && reg_size == SZ_BYTE) |=> (page_en == $past(reg_wdata[NPAGE-1:0])));

    // R4: a wrong-width access leaves the enables untouched
    assert_bad_size_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_valid && reg_size != SZ_BYTE) |=> $stable(page_en));
endmodule

// File: rtl/pgram_post_buf.sv
module pgram_post_buf
    import pgram_pkg::*;
#(
    parameter int unsigned AW = 10,
    parameter int unsigned DW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_req,
    input  logic [AW-1:0]    wr_addr,
    input  logic [DW-1:0]    wr_data,
    input  logic [NPAGE-1:0] page_en,
    output logic             cm_we,
    output logic [AW-1:0]    pend_addr,
    output logic [DW-1:0]    pend_data,
    output logic             pend_v
);
    typedef struct packed {
        logic          v;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } ent_t;

    ent_t ent_d, ent_q;

    always_comb begin
        ent_d   = ent_q;
        ent_d.v = wr_req;
        if (wr_req) begin
            ent_d.addr = wr_addr;
            ent_d.data = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_q <= '0;
        end else begin
            ent_q <= ent_d;
        end
    end

    // The entry drains every cycle; the page enable is checked again at commit.
    assign cm_we     = ent_q.v && page_en[ent_q.addr[AW-1 -: PAGE_W]];
    assign pend_addr = ent_q.addr;
    assign pend_data = ent_q.data;
    assign pend_v    = ent_q.v;
endmodule

// File: rtl/pgram_array.sv
module pgram_array #(
    parameter int unsigned AW = 10,
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] rd_q;

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rd_q <= mem[raddr];
    end

    assign rdata = rd_q;
endmodule

// File: rtl/pgram_top.sv
module pgram_top
    import pgram_pkg::*;
#(
    parameter int unsigned PAGE_AW  = 8,
    parameter int unsigned DW       = 32,
    parameter bit          POISON_X = 1'b0,
    parameter logic [DW-1:0] POISON = 32'hDEAD_DEAD,
    localparam int unsigned AW      = PAGE_AW + PAGE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ram_valid,
    input  logic          ram_we,
    input  logic [AW-1:0] ram_addr,
    input  logic [DW-1:0] ram_wdata,
    output logic [DW-1:0] ram_rdata,
    output logic          ram_rvalid,
    output logic          ram_hazard,
    input  logic          reg_valid,
    input  logic          reg_we,
    input  logic [1:0]    reg_size,
    input  logic [7:0]    reg_wdata,
    output logic [7:0]    reg_rdata,
    output logic          reg_err
);
    typedef struct packed {
        logic          rvalid;
        rsrc_e         src;
        logic [DW-1:0] fwd;
    } rd_t;

    logic [NPAGE-1:0] page_en;
    logic             wr_last;
    logic             wr_req;
    logic             cm_we;
    logic             pend_v;
    logic [AW-1:0]    pend_addr;
    logic [DW-1:0]    pend_data;
    logic [DW-1:0]    arr_rdata;
    logic [DW-1:0]    poison_w;
    logic             acc_en;
    rd_t              rd_d, rd_q;

    generate
        if (POISON_X) begin : g_px
            assign poison_w = 'x;
        end else begin : g_pv
            assign poison_w = POISON;
        end
    endgenerate

    pgram_ctrl_reg u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .reg_valid(reg_valid), .reg_we(reg_we), .reg_size(reg_size),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_err(reg_err),
        .page_en(page_en), .wr_last(wr_last)
    );

    assign acc_en = page_en[ram_addr[AW-1 -: PAGE_W]];
    assign wr_req = ram_valid && ram_we && acc_en;

    pgram_post_buf #(.AW(AW), .DW(DW)) u_buf (
        .clk(clk), .rst_n(rst_n),
        .wr_req(wr_req), .wr_addr(ram_addr), .wr_data(ram_wdata),
        .page_en(page_en), .cm_we(cm_we),
        .pend_addr(pend_addr), .pend_data(pend_data), .pend_v(pend_v)
    );

    pgram_array #(.AW(AW), .DW(DW)) u_arr (
        .clk(clk), .we(cm_we), .waddr(pend_addr), .wdata(pend_data),
        .raddr(ram_addr), .rdata(arr_rdata)
    );

    always_comb begin
        rd_d        = rd_q;
        rd_d.rvalid = ram_valid && !ram_we;
        rd_d.src    = SRC_ARRAY;
        if (!acc_en) begin
            rd_d.src = SRC_POISON;
        end else if (cm_we && pend_addr == ram_addr) begin
            rd_d.src = SRC_FWD;
            rd_d.fwd = pend_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    always_comb begin
        case (rd_q.src)
            SRC_FWD:    ram_rdata = rd_q.fwd;
            SRC_POISON: ram_rdata = poison_w;
            default:    ram_rdata = arr_rdata;
        endcase
    end

    assign ram_rvalid = rd_q.rvalid;
    assign ram_hazard = ram_valid && wr_last;

    // R5: a write to a disabled page never enters the posted buffer
    assert_drop_disabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_valid && ram_we && !page_en[ram_addr[AW-1 -: PAGE_W]]) |=> !pend_v);

    // R7: every read request is answered one cycle later
    assert_read_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_valid && !ram_we) |=> ram_rvalid);

    // R9: an access right after a register write is flagged
    assert_hazard_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_valid && $past(reg_valid && reg_we && reg_size == SZ_BYTE)) |-> ram_hazard);

    generate
        if (!POISON_X) begin : g_pchk
            // R6: reads of a switched-off page return the poison pattern
            assert_poison_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (ram_valid && !ram_we && !page_en[ram_addr[AW-1 -: PAGE_W]]) |=> (ram_rdata == POISON));
        end
    endgenerate
endmodule

// File: tb/pgram_top_tb.sv
module pgram_top_tb;
    localparam int AW = 10;
    localparam int DW = 32;
    localparam logic [DW-1:0] POISON = 32'hDEAD_DEAD;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ram_valid = 1'b0;
    logic          ram_we = 1'b0;
    logic [AW-1:0] ram_addr = '0;
    logic [DW-1:0] ram_wdata = '0;
    logic [DW-1:0] ram_rdata;
    logic          ram_rvalid;
    logic          ram_hazard;
    logic          reg_valid = 1'b0;
    logic          reg_we = 1'b0;
    logic [1:0]    reg_size = 2'd0;
    logic [7:0]    reg_wdata = '0;
    logic [7:0]    reg_rdata;
    logic          reg_err;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    pgram_top u_dut (
        .clk(clk), .rst_n(rst_n),
        .ram_valid(ram_valid), .ram_we(ram_we), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata), .ram_rvalid(ram_rvalid),
        .ram_hazard(ram_hazard),
        .reg_valid(reg_valid), .reg_we(reg_we), .reg_size(reg_size),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_err(reg_err)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic reg_write(input logic [7:0] d, input logic [1:0] sz);
        @(negedge clk);
        reg_valid = 1; reg_we = 1; reg_size = sz; reg_wdata = d;
        @(negedge clk);
        reg_valid = 0; reg_we = 0; reg_size = 0;
    endtask

    task automatic reg_read(input logic [1:0] sz, output logic [7:0] d, output logic e);
        @(negedge clk);
        reg_valid = 1; reg_we = 0; reg_size = sz;
        #1;
        d = reg_rdata; e = reg_err;
        @(negedge clk);
        reg_valid = 0; reg_size = 0;
    endtask

    task automatic ram_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        ram_valid = 1; ram_we = 1; ram_addr = a; ram_wdata = d;
        @(negedge clk);
        ram_valid = 0; ram_we = 0;
    endtask

    task automatic ram_read(input logic [AW-1:0] a, output logic [DW-1:0] d, output logic v);
        @(negedge clk);
        ram_valid = 1; ram_we = 0; ram_addr = a;
        @(negedge clk);
        ram_valid = 0;
        d = ram_rdata; v = ram_rvalid;
    endtask

    task automatic t_reset();
        logic [7:0] d; logic e;
        reg_read(2'd0, d, e);
        check("R1 reset value", d, 8'hFF);
        check("R1 no error", e, 0);
    endtask

    task automatic t_reg();
        logic [7:0] d; logic e;
        reg_write(8'h05, 2'd0);
        reg_read(2'd0, d, e);
        check("R3 enables updated", d, 8'hF5);
        reg_write(8'h00, 2'd0);
        reg_read(2'd0, d, e);
        check("R2 reserved read as one", d, 8'hF0);
        // R3: read in the very cycle after the write sees the new value
        @(negedge clk);
        reg_valid = 1; reg_we = 1; reg_wdata = 8'h0A;
        @(negedge clk);
        reg_we = 0; #1;
        check("R3 same later cycle", reg_rdata, 8'hFA);
        @(negedge clk);
        reg_valid = 0;
        reg_write(8'h0F, 2'd0);
    endtask

    task automatic t_bad_size();
        logic [7:0] d; logic e;
        @(negedge clk);
        reg_valid = 1; reg_we = 1; reg_size = 2'd2; reg_wdata = 8'h00;
        #1;
        check("R4 error on word write", reg_err, 1);
        @(negedge clk);
        reg_valid = 0; reg_we = 0; reg_size = 0;
        reg_read(2'd1, d, e);
        check("R4 half read data zero", d, 0);
        check("R4 half read error", e, 1);
        reg_read(2'd0, d, e);
        check("R4 register unchanged", d, 8'hFF);
    endtask

    task automatic t_rw();
        logic [DW-1:0] d; logic v;
        ram_write(10'h005, 32'h1234_5678);
        ram_write(10'h1FF, 32'hCAFE_0001);
        ram_write(10'h3C0, 32'h0BAD_F00D);
        ram_read(10'h005, d, v);
        check("R7 page0 data", d, 32'h1234_5678);
        check("R7 rvalid", v, 1);
        ram_read(10'h1FF, d, v);
        check("R7 page1 data", d, 32'hCAFE_0001);
        ram_read(10'h3C0, d, v);
        check("R7 page3 data", d, 32'h0BAD_F00D);
        // back-to-back write then read of same word
        @(negedge clk);
        ram_valid = 1; ram_we = 1; ram_addr = 10'h2AA; ram_wdata = 32'h5555_AAAA;
        @(negedge clk);
        ram_we = 0;
        @(negedge clk);
        ram_valid = 0;
        check("R7 read after write forward", ram_rdata, 32'h5555_AAAA);
    endtask

    task automatic t_disabled();
        logic [DW-1:0] d; logic v;
        ram_write(10'h210, 32'h1111_2222);
        reg_write(8'h0B, 2'd0);
        ram_write(10'h210, 32'h9999_9999);
        ram_read(10'h210, d, v);
        check("R6 poison on disabled", d, POISON);
        check("R6 rvalid on disabled", v, 1);
        reg_write(8'h0F, 2'd0);
        ram_read(10'h210, d, v);
        check("R5 contents kept", d, 32'h1111_2222);
    endtask

    task automatic t_lost();
        logic [DW-1:0] d; logic v;
        ram_write(10'h150, 32'hAAAA_0000);
        @(negedge clk);
        ram_valid = 1; ram_we = 1; ram_addr = 10'h150; ram_wdata = 32'hBBBB_1111;
        reg_valid = 1; reg_we = 1; reg_size = 0; reg_wdata = 8'h0D;
        @(negedge clk);
        ram_valid = 0; ram_we = 0; reg_valid = 0; reg_we = 0;
        reg_write(8'h0F, 2'd0);
        ram_read(10'h150, d, v);
        check("R8 write lost on disable", d, 32'hAAAA_0000);
        ram_write(10'h150, 32'hCCCC_2222);
        reg_write(8'h0D, 2'd0);
        reg_write(8'h0F, 2'd0);
        ram_read(10'h150, d, v);
        check("R8 committed write kept", d, 32'hCCCC_2222);
    endtask

    task automatic t_hazard();
        reg_write(8'h0F, 2'd0);
        ram_valid = 1; ram_we = 0; ram_addr = 10'h005;
        #1;
        check("R9 hazard after reg write", ram_hazard, 1);
        @(negedge clk);
        #1;
        check("R9 hazard clears", ram_hazard, 0);
        @(negedge clk);
        ram_valid = 0;
        reg_write(8'h0F, 2'd0);
        @(negedge clk);
        ram_valid = 1; #1;
        check("R9 no hazard after gap", ram_hazard, 0);
        @(negedge clk);
        ram_valid = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_reg();
        t_bad_size();
        t_rw();
        t_disabled();
        t_lost();
        t_hazard();
        repeat (2) @(negedge clk);
        report();
    end
endmodule